// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block holds a bank of independent interrupt vectors. Each vector counts completion events as a signed credit balance and runs a countdown that holds the interrupt back so that several completions are grouped into one. A vector drives its interrupt line only when it is unmasked, its balance is above zero and its countdown has reached zero. The countdown moves one step on each pulse of a shared prescaler tick.

Software uses a plain 32-bit register port: a write strobe, a byte address, write data and read data that follows the address combinationally. Each vector owns a 32-byte window. Through that window software sets the countdown reload value, masks or unmasks the vector, returns credits and chooses the mask state that the vector takes on by itself once its interrupt fires. A credit return is a signed count. Two flag bits in the same write can unmask the vector and restart its countdown, so one write re-arms the vector.

Top module: `intr_coal_bank`

## Requirements
- R1: After reset every vector is masked, with credit balance 0, reload value 0, mask-on-fire value 0 and countdown 0, and every interrupt output is low.
- R2: The vector index is taken from the address bits above bit 4, and the word is taken from address bits [4:2]. Word 0 is the reload value, 1 is the mask, 2 is the credits, 3 is the mask-on-fire value, 4 is the countdown (read-only) and 5 to 7 are reserved. The reload value keeps only write bits [5:0]. Reserved words, and every word of a vector index at or above the vector count, read as zero and ignore writes.
- R3: An event pulse adds one to the vector's credit balance. The balance does not rise past 32767.
- R4: A write to the credits word subtracts write bits [15:0], read as a two's-complement count, from the balance. The result is clamped to the range -32768 to 32767. An event in the same cycle is added before clamping. A read of the credits word returns the balance in bits [15:0], with bits [31:16] zero.
- R5: A credits write with bit 16 set clears the mask in the next cycle.
- R6: A credits write with bit 17 set loads the countdown from the reload value in the next cycle.
- R7: On each tick the countdown drops by one while it is above zero. It stays at zero when it reaches zero, and it never changes without a tick or a reload.
- R8: A vector's interrupt output is high exactly when its mask is 0, its balance is greater than zero and its countdown is zero.
- R9: In each cycle where a vector's interrupt is high, its mask takes the mask-on-fire value (write bit 0 of word 3) at the next edge. A mask write or a credits unmask in that cycle takes priority.
- R10: A write to the mask word sets the mask to write bit 0, where 1 means masked. Mask and mask-on-fire read back in bit 0.
- R11: Events, writes and ticks on one vector leave the state of every other vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler pulse that steps all countdowns |
| evt | input | NVEC | One completion-event pulse per vector |
| req_wr | input | 1 | Write strobe for the register port |
| req_addr | input | ADDR_W | Byte address (ADDR_W = clog2(NVEC)+5) |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for req_addr, combinational |
| irq | output | NVEC | Interrupt line per vector |

## Verification
The bench builds the bank with three vectors and a 6-bit countdown. The vector count is not a power of two, so index 3 decodes to an empty slot, and the bench can check that this slot reads zero and ignores writes. A 6-bit countdown reaches its limit of 63 in a few dozen ticks. Random reload values therefore let interrupts fire, self-mask and be re-armed many times in one run. Directed returns of extreme signed counts drive the balance into both clamp limits.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int CRED_W     = 16;
  localparam int STRIDE_LG  = 5;
  localparam int UNMASK_BIT = 16;
  localparam int ARM_BIT    = 17;

  localparam logic [2:0] WD_RELOAD = 3'd0;
  localparam logic [2:0] WD_MASK   = 3'd1;
  localparam logic [2:0] WD_CRED   = 3'd2;
  localparam logic [2:0] WD_MOF    = 3'd3;
  localparam logic [2:0] WD_TMR    = 3'd4;

  // balance + inc - sub, clamped to the signed 16-bit range
  function automatic logic [CRED_W-1:0] cred_next(
    input logic [CRED_W-1:0] cur,
    input logic              inc,
    input logic              sub_en,
    input logic [CRED_W-1:0] sub
  );
    logic signed [CRED_W+1:0] sum;
    logic signed [CRED_W+1:0] s_cur;
    logic signed [CRED_W+1:0] s_sub;
    s_cur = {{2{cur[CRED_W-1]}}, cur};
    s_sub = sub_en ? {{2{sub[CRED_W-1]}}, sub} : '0;
    sum   = s_cur + {{(CRED_W+1){1'b0}}, inc} - s_sub;
    if (sum > 18'sd32767)       return 16'h7FFF;
    else if (sum < -18'sd32768) return 16'h8000;
    else                        return sum[CRED_W-1:0];
  endfunction

  function automatic logic cred_pos(input logic [CRED_W-1:0] c);
    return !c[CRED_W-1] && (c != '0);
  endfunction
endpackage

// File: rtl/icc_decode.sv
module icc_decode #(
  parameter int NVEC   = 4,
  parameter int ADDR_W = $clog2(NVEC) + 5
) (
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  output logic [ADDR_W-icc_pkg::STRIDE_LG-1:0] vidx,
  output logic [2:0]                    word,
  output logic                          vec_ok,
  output logic [NVEC-1:0]               wr_sel
);
  localparam int VIDX_W = ADDR_W - icc_pkg::STRIDE_LG;

  always_comb begin
    vidx   = addr[ADDR_W-1:icc_pkg::STRIDE_LG];
    word   = addr[4:2];
    vec_ok = (32'(vidx) < NVEC);
  end

  for (genvar v = 0; v < NVEC; v++) begin : g_sel
    assign wr_sel[v] = wr && vec_ok && (vidx == VIDX_W'(v));
  end
endmodule

// File: rtl/icc_vector.sv
module icc_vector #(
  parameter int TMR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      evt,
  input  logic                      wr_sel,
  input  logic [2:0]                word,
  input  logic [17:0]               wdata,
  output logic [TMR_W-1:0]          rld,
  output logic                      mask,
  output logic [icc_pkg::CRED_W-1:0] cred,
  output logic                      mof,
  output logic [TMR_W-1:0]          tmr,
  output logic                      irq,
  output logic                      cred_wr,
  output logic                      unmask_req,
  output logic                      arm_req,
  output logic                      mask_wr
);
  import icc_pkg::*;

  logic             mask_nxt;
  logic [TMR_W-1:0] tmr_nxt;

  assign cred_wr    = wr_sel && (word == WD_CRED);
  assign unmask_req = cred_wr && wdata[UNMASK_BIT];
  assign arm_req    = cred_wr && wdata[ARM_BIT];
  assign mask_wr    = wr_sel && (word == WD_MASK);

  assign irq = !mask && cred_pos(cred) && (tmr == '0);

  always_comb begin
    if (mask_wr)         mask_nxt = wdata[0];
    else if (unmask_req) mask_nxt = 1'b0;
    else if (irq)        mask_nxt = mof;
    else                 mask_nxt = mask;
  end

  always_comb begin
    if (arm_req)                 tmr_nxt = rld;
    else if (tick && tmr != '0)  tmr_nxt = tmr - 1'b1;
    else                         tmr_nxt = tmr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld  <= '0;
      mask <= 1'b1;
      cred <= '0;
      mof  <= 1'b0;
      tmr  <= '0;
    end else begin
      if (wr_sel && word == WD_RELOAD) rld <= wdata[TMR_W-1:0];
      if (wr_sel && word == WD_MOF)    mof <= wdata[0];
      cred <= cred_next(cred, evt, cred_wr, wdata[CRED_W-1:0]);
      mask <= mask_nxt;
      tmr  <= tmr_nxt;
    end
  end
endmodule

// File: rtl/intr_coal_bank.sv
module intr_coal_bank #(
  parameter int NVEC   = 4,
  parameter int TMR_W  = 6,
  parameter int ADDR_W = $clog2(NVEC) + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NVEC-1:0]   evt,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rdata,
  output logic [NVEC-1:0]   irq
);
  import icc_pkg::*;
  localparam int VIDX_W = ADDR_W - STRIDE_LG;

  logic [VIDX_W-1:0] vidx;
  logic [2:0]        word;
  logic              vec_ok;
  logic [NVEC-1:0]   wr_sel;

  // per-vector state and strobes, named for the checker
  logic [NVEC-1:0][TMR_W-1:0]  rld_st;
  logic [NVEC-1:0][TMR_W-1:0]  tmr_st;
  logic [NVEC-1:0][CRED_W-1:0] cred_st;
  logic [NVEC-1:0]             mask_st;
  logic [NVEC-1:0]             mof_st;
  logic [NVEC-1:0]             cwr_v;
  logic [NVEC-1:0]             unm_v;
  logic [NVEC-1:0]             arm_v;
  logic [NVEC-1:0]             mwr_v;

  icc_decode #(.NVEC(NVEC), .ADDR_W(ADDR_W)) u_dec (
    .wr(req_wr), .addr(req_addr), .vidx(vidx), .word(word),
    .vec_ok(vec_ok), .wr_sel(wr_sel)
  );

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    icc_vector #(.TMR_W(TMR_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt[v]),
      .wr_sel(wr_sel[v]), .word(word), .wdata(req_wdata[17:0]),
      .rld(rld_st[v]), .mask(mask_st[v]), .cred(cred_st[v]),
      .mof(mof_st[v]), .tmr(tmr_st[v]), .irq(irq[v]),
      .cred_wr(cwr_v[v]), .unmask_req(unm_v[v]), .arm_req(arm_v[v]),
      .mask_wr(mwr_v[v])
    );
  end

  always_comb begin
    rdata = '0;
    if (vec_ok) begin
      case (word)
        WD_RELOAD: rdata = 32'(rld_st[vidx]);
        WD_MASK:   rdata = 32'(mask_st[vidx]);
        WD_CRED:   rdata = 32'(cred_st[vidx]);
        WD_MOF:    rdata = 32'(mof_st[vidx]);
        WD_TMR:    rdata = 32'(tmr_st[vidx]);
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/icc_chk.sv
module icc_chk #(
  parameter int NVEC  = 4,
  parameter int TMR_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [NVEC-1:0]        irq,
  input logic [NVEC-1:0][TMR_W-1:0] rld_st,
  input logic [NVEC-1:0][TMR_W-1:0] tmr_st,
  input logic [NVEC-1:0][15:0]  cred_st,
  input logic [NVEC-1:0]        mask_st,
  input logic [NVEC-1:0]        mof_st,
  input logic [NVEC-1:0]        cwr_v,
  input logic [NVEC-1:0]        unm_v,
  input logic [NVEC-1:0]        arm_v,
  input logic [NVEC-1:0]        mwr_v
);
  for (genvar i = 0; i < NVEC; i++) begin : g_chk
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && tmr_st[i] != '0 && !arm_v[i]) |=> (tmr_st[i] == TMR_W'($past(tmr_st[i]) - 1'b1))); // R7
    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_st[i] == '0 && !arm_v[i]) |=> (tmr_st[i] == '0)); // R7
    AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      arm_v[i] |=> (tmr_st[i] == $past(rld_st[i]))); // R6
    AST_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
      (unm_v[i] && !mwr_v[i]) |=> !mask_st[i]); // R5
    AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !mwr_v[i] && !unm_v[i]) |=> (mask_st[i] == $past(mof_st[i]))); // R9
    AST_CRED_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      (cred_st[i] == 16'h7FFF && !cwr_v[i]) |=> (cred_st[i] == 16'h7FFF)); // R3
  end
endmodule

bind intr_coal_bank icc_chk #(.NVEC(NVEC), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .irq(irq),
  .rld_st(rld_st), .tmr_st(tmr_st), .cred_st(cred_st),
  .mask_st(mask_st), .mof_st(mof_st), .cwr_v(cwr_v),
  .unm_v(unm_v), .arm_v(arm_v), .mwr_v(mwr_v)
);

// File: tb/tb_intr_coal_bank.sv
`timescale 1ns/1ps
module tb_intr_coal_bank;
  localparam int NV = 3;
  localparam int AW = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          tick = 0;
  logic [NV-1:0] evt = '0;
  logic          req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rdata;
  logic [NV-1:0] irq;

  int total = 0;
  int bad = 0;

  // reference state
  int m_rld[NV];
  int m_cred[NV];
  bit m_mask[NV];
  bit m_mof[NV];
  int m_tmr[NV];

  always #4 clk = ~clk;

  intr_coal_bank #(.NVEC(NV), .TMR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] ad(input int v, input int w);
    return AW'(v * 32 + w * 4);
  endfunction

  function automatic bit m_irq(input int v);
    return !m_mask[v] && m_cred[v] > 0 && m_tmr[v] == 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    int v = int'(a[AW-1:5]);
    int w = int'(a[4:2]);
    if (v >= NV) return 32'h0;
    case (w)
      0: return 32'(m_rld[v]);
      1: return 32'(m_mask[v]);
      2: return {16'h0, 16'(m_cred[v])};
      3: return 32'(m_mof[v]);
      4: return 32'(m_tmr[v]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    if (int'(a[AW-1:5]) >= NV) return "R2";
    case (int'(a[4:2]))
      0: return "R2";
      1: return "R10";
      2: return "R4";
      3: return "R10";
      4: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic m_step(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [NV-1:0] e, input bit t);
    bit fire[NV];
    for (int v = 0; v < NV; v++) fire[v] = m_irq(v);
    for (int v = 0; v < NV; v++) begin
      bit hit = wr && int'(a[AW-1:5]) == v;
      int w = int'(a[4:2]);
      bit cw = hit && w == 2;
      int c = m_cred[v] + int'(e[v]);
      if (cw) c = c - int'($signed(d[15:0]));
      if (c > 32767) c = 32767;
      if (c < -32768) c = -32768;
      if (hit && w == 1)       m_mask[v] = d[0];
      else if (cw && d[16])    m_mask[v] = 0;
      else if (fire[v])        m_mask[v] = m_mof[v];
      if (cw && d[17])                  m_tmr[v] = m_rld[v];
      else if (t && m_tmr[v] > 0)       m_tmr[v] = m_tmr[v] - 1;
      m_cred[v] = c;
      if (hit && w == 0) m_rld[v] = int'(d[5:0]);
      if (hit && w == 3) m_mof[v] = d[0];
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus; reads are compared before the edge
  task automatic cyc(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [NV-1:0] e, input bit t, input string tag = "");
    req_wr = wr; req_addr = a; req_wdata = d; evt = e; tick = t;
    #1;
    if (!wr) check(rdata, m_read(a), tag == "" ? tag_of(a) : tag);
    for (int v = 0; v < NV; v++) check(32'(irq[v]), 32'(m_irq(v)), "R8");
    @(posedge clk);
    m_step(wr, a, d, e, t);
    @(negedge clk);
  endtask

  task automatic wr_reg(input int v, input int w, input logic [31:0] d);
    cyc(1, ad(v, w), d, '0, 0);
  endtask

  task automatic probe(input int v, input int w, input string tag);
    cyc(0, ad(v, w), 32'h0, '0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int v = 0; v < NV; v++) begin
      m_rld[v] = 0; m_cred[v] = 0; m_mask[v] = 1; m_mof[v] = 0; m_tmr[v] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check(32'(irq), 32'h0, "R1");
    for (int v = 0; v < NV; v++)
      for (int w = 0; w < 5; w++) probe(v, w, "R1");

    // R2: reload keeps 6 bits, reserved and empty slot read zero
    wr_reg(0, 0, 32'hFFFF_FF7F);
    probe(0, 0, "R2");
    wr_reg(0, 5, 32'hFFFF_FFFF);
    probe(0, 5, "R2");
    wr_reg(3, 2, 32'h0003_8001);
    for (int w = 0; w < 8; w++) probe(3, w, "R2");
    probe(1, 2, "R11");

    // R3: balance reaches and holds the upper clamp
    wr_reg(1, 2, 32'h0000_8001);
    probe(1, 2, "R3");
    cyc(0, ad(1, 2), 32'h0, 3'b010, 0, "R3");
    probe(1, 2, "R3");
    // R4: clamps at both ends, upper flag-free bits ignored
    wr_reg(1, 2, 32'hFFFC_8000);
    probe(1, 2, "R4");
    wr_reg(2, 2, 32'h0000_7FFF);
    probe(2, 2, "R4");
    wr_reg(2, 2, 32'h0000_7FFF);
    probe(2, 2, "R4");
    cyc(1, ad(2, 2), 32'h0000_0003, 3'b100, 0);
    probe(2, 2, "R4");
    probe(0, 2, "R11");

    // R5, R6, R7, R8, R9: arm vector 0 and let it fire once
    wr_reg(0, 3, 32'h1);
    probe(0, 3, "R10");
    wr_reg(0, 2, 32'h0003_FFFE);
    probe(0, 1, "R5");
    probe(0, 4, "R6");
    for (int k = 0; k < 63; k++) cyc(0, ad(0, 4), 32'h0, '0, 1, "R7");
    check(32'(irq[0]), 32'h1, "R8");
    probe(0, 1, "R9");
    check(32'(irq[0]), 32'h0, "R9");
    cyc(0, ad(0, 4), 32'h0, '0, 1, "R7");
    // R10: manual unmask refires, mask-on-fire cleared keeps it on
    wr_reg(0, 3, 32'h0);
    wr_reg(0, 1, 32'h0);
    probe(0, 1, "R10");
    check(32'(irq[0]), 32'h1, "R8");
    probe(0, 1, "R9");
    wr_reg(0, 1, 32'h1);
    probe(0, 1, "R10");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      bit wr = ($urandom % 3) == 0;
      int v = $urandom % 4;
      int w = $urandom % 8;
      logic [31:0] d = $urandom;
      if (w == 2 && ($urandom % 4) != 0)
        d = {d[31:16], 16'($signed(int'($urandom % 9) - 4))};
      if (w == 0 && ($urandom % 2) == 0) d[5:0] = 6'($urandom % 8);
      cyc(wr, ad(v, w), d, NV'($urandom), ($urandom % 2) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule